// File: doc/BRIEF.md
# Seven-Byte Group Serial Packet Receiver

This block takes one serial data line and turns it into stored packet bytes. It samples the line once per bit cell of `CLK_PER_BIT` clocks. The default is 500 clocks, which gives a 4 us cell at 125 MHz and so 32 us per wire byte. It finds byte alignment at the first set bit after the line has been idle. From then on it reads 8-bit wire bytes, most significant bit first, without a gap between them. Every legal wire byte has its top bit set, so a wire byte can only carry seven payload bits.

The wire bytes arrive in groups of up to eight. The first byte of a group is a header and is never stored. Header bits 6 down to 0 hold the original top bits of the up to seven data bytes that follow it, in that order. The receiver puts each top bit back on its data byte and writes the restored byte to a packet buffer port, at addresses that rise from zero. A one-cycle end-of-packet input closes the packet. The block then pulses done and reports how many bytes were stored. It re-arms to look for the next packet.

A wire byte with a clear top bit stops storage for the rest of the packet. Bytes beyond the buffer capacity (`MAX_BYTES`, default 512) are dropped and raise an overflow flag.

Top module: `sevgrp_rx`

## Requirements
- R1: After reset, wr_en_o, done_o, frame_err_o and ovf_o are 0 and done_count_o is 0.
- R2: While idle the receiver waits for the line to be 1. That first 1 is bit 7 of the first wire byte. Each bit is sampled near the middle of its `CLK_PER_BIT` cell, and bits arrive most significant first, with wire bytes back to back.
- R3: The first wire byte of each group of eight (wire positions 0, 8, 16, ... counted from the packet start) is a header and is never written.
- R4: The k-th data byte of a group (k = 1..7) is written with bit 7 equal to header bit (7-k) and bits 6:0 equal to the wire byte's bits 6:0. So header bit 6 restores the first data byte and header bit 0 restores the seventh.
- R5: Each packet's stored bytes are written with single-cycle wr_en_o pulses at addresses 0, 1, 2, ... in arrival order.
- R6: A one-cycle eop_i pulse produces a one-cycle done_o pulse on the next cycle. done_count_o then equals the number of bytes stored, and it includes the bytes of a group that was only partly sent.
- R7: A wire byte with bit 7 equal to 0 sets frame_err_o. No further writes happen until the next packet starts, and the flag clears when the next packet's first set bit is seen.
- R8: Once `MAX_BYTES` bytes are stored, further data bytes are not written and ovf_o is set. done_count_o reports `MAX_BYTES`, and ovf_o clears when the next packet starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial data line |
| eop_i | input | 1 | End-of-packet pulse |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | $clog2(MAX_BYTES) | Buffer write address |
| wr_data_o | output | 8 | Restored data byte |
| done_o | output | 1 | Packet-done pulse |
| done_count_o | output | $clog2(MAX_BYTES+1) | Bytes stored in the last packet |
| frame_err_o | output | 1 | Framing-error flag |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench uses a small configuration and sweeps every packet length from zero to the buffer capacity with four data patterns:
- **All zeros:** every header bit is 0, so a design that leaves the top bit set fails.
- **All ones:** every restored top bit is 1, so a design that drops the header bit fails.
- **Alternating bytes:** neighbouring bytes differ in their top bit, so a reversed header bit order shows up.
- **Arithmetic sequence:** it mixes all bit positions, so a dropped, doubled or reordered byte shows up.

Lengths that are not a multiple of seven test the handling of partial groups. Longer lengths cross several headers and so check the group counting. Packets longer than the capacity, and packets with an illegal wire byte in the middle, check that storage stops exactly where it should. Each of these is followed by a clean packet, which checks that both flags clear.

// File: rtl/sevgrp_pkg.sv
package sevgrp_pkg;
  typedef logic [7:0] byte_t;
  typedef enum logic [0:0] {SMP_HUNT, SMP_RUN} smp_state_e;
  localparam int unsigned GRP_LEN = 8;  // header + seven data bytes
endpackage

// File: rtl/sevgrp_sampler.sv
module sevgrp_sampler
  import sevgrp_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 500
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rx_i,
  input  logic  flush_i,
  output logic  start_o,
  output logic  byte_vld_o,
  output byte_t byte_o
);
  localparam int unsigned CW   = $clog2(CLK_PER_BIT);
  localparam int unsigned HALF = CLK_PER_BIT / 2;

  logic          rx_q1, rx_q2;
  smp_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [6:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q1 <= 1'b0;
      rx_q2 <= 1'b0;
    end else begin
      rx_q1 <= rx_i;
      rx_q2 <= rx_q1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SMP_HUNT;
      cnt_q      <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      start_o    <= 1'b0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      start_o    <= 1'b0;
      byte_vld_o <= 1'b0;
      if (flush_i) begin
        state_q <= SMP_HUNT;
      end else begin
        unique case (state_q)
          SMP_HUNT: if (rx_q2) begin
            // first set bit after idle marks bit 7 of the first wire byte
            state_q <= SMP_RUN;
            cnt_q   <= CW'(HALF - 1);
            bit_q   <= '0;
            start_o <= 1'b1;
          end
          SMP_RUN: begin
            if (cnt_q == '0) begin
              cnt_q <= CW'(CLK_PER_BIT - 1);
              sh_q  <= {sh_q[5:0], rx_q2};
              bit_q <= bit_q + 3'd1;
              if (bit_q == 3'd7) begin
                byte_vld_o <= 1'b1;
                byte_o     <= {sh_q, rx_q2};
              end
            end else begin
              cnt_q <= cnt_q - CW'(1);
            end
          end
          default: state_q <= SMP_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/sevgrp_group.sv
module sevgrp_group
  import sevgrp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  logic  start_i,
  input  logic  byte_vld_i,
  input  byte_t byte_i,
  output logic  wr_req_o,
  output byte_t wr_byte_o,
  output logic  frame_err_o
);
  logic [2:0] slot_q;
  byte_t      hdr_q;
  logic [2:0] hdr_idx;

  // slot k (1..7) takes header bit 7-k
  assign hdr_idx   = 3'd7 - slot_q;
  assign wr_req_o  = byte_vld_i && byte_i[7] && !frame_err_o && !flush_i && (slot_q != '0);
  assign wr_byte_o = {hdr_q[hdr_idx], byte_i[6:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q      <= '0;
      hdr_q       <= '0;
      frame_err_o <= 1'b0;
    end else if (flush_i) begin
      slot_q <= '0;
    end else if (start_i) begin
      slot_q      <= '0;
      frame_err_o <= 1'b0;
    end else if (byte_vld_i && !frame_err_o) begin
      if (!byte_i[7]) begin
        frame_err_o <= 1'b1;
      end else begin
        if (slot_q == '0) hdr_q <= byte_i;
        slot_q <= (slot_q == 3'(GRP_LEN - 1)) ? 3'd0 : slot_q + 3'd1;
      end
    end
  end
endmodule

// File: rtl/sevgrp_writer.sv
module sevgrp_writer
  import sevgrp_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 512
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_req_i,
  input  byte_t                              wr_byte_i,
  input  logic                               eop_i,
  input  logic                               start_i,
  output logic                               wr_en_o,
  output logic [$clog2(MAX_BYTES)-1:0]       wr_addr_o,
  output byte_t                              wr_data_o,
  output logic                               done_o,
  output logic [$clog2(MAX_BYTES+1)-1:0]     done_count_o,
  output logic                               ovf_o
);
  localparam int unsigned AW   = $clog2(MAX_BYTES);
  localparam int unsigned CNTW = $clog2(MAX_BYTES + 1);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      wr_en_o      <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
      done_o       <= 1'b0;
      done_count_o <= '0;
      ovf_o        <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      if (eop_i) begin
        done_o       <= 1'b1;
        done_count_o <= cnt_q;
        cnt_q        <= '0;
      end else begin
        if (start_i) ovf_o <= 1'b0;
        if (wr_req_i) begin
          if (cnt_q < CNTW'(MAX_BYTES)) begin
            wr_en_o   <= 1'b1;
            wr_addr_o <= cnt_q[AW-1:0];
            wr_data_o <= wr_byte_i;
            cnt_q     <= cnt_q + CNTW'(1);
          end else begin
            ovf_o <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sevgrp_rx.sv
module sevgrp_rx
  import sevgrp_pkg::*;
#(
  parameter int unsigned CLK_PER_BIT = 500,
  parameter int unsigned MAX_BYTES   = 512
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rx_i,
  input  logic                           eop_i,
  output logic                           wr_en_o,
  output logic [$clog2(MAX_BYTES)-1:0]   wr_addr_o,
  output logic [7:0]                     wr_data_o,
  output logic                           done_o,
  output logic [$clog2(MAX_BYTES+1)-1:0] done_count_o,
  output logic                           frame_err_o,
  output logic                           ovf_o
);
  logic  start, byte_vld, wr_req;
  byte_t wire_byte, wr_byte;

  sevgrp_sampler #(.CLK_PER_BIT(CLK_PER_BIT)) u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_i       (rx_i),
    .flush_i    (eop_i),
    .start_o    (start),
    .byte_vld_o (byte_vld),
    .byte_o     (wire_byte)
  );

  sevgrp_group u_grp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (eop_i),
    .start_i     (start),
    .byte_vld_i  (byte_vld),
    .byte_i      (wire_byte),
    .wr_req_o    (wr_req),
    .wr_byte_o   (wr_byte),
    .frame_err_o (frame_err_o)
  );

  sevgrp_writer #(.MAX_BYTES(MAX_BYTES)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_req_i     (wr_req),
    .wr_byte_i    (wr_byte),
    .eop_i        (eop_i),
    .start_i      (start),
    .wr_en_o      (wr_en_o),
    .wr_addr_o    (wr_addr_o),
    .wr_data_o    (wr_data_o),
    .done_o       (done_o),
    .done_count_o (done_count_o),
    .ovf_o        (ovf_o)
  );
endmodule

// File: rtl/sevgrp_rx_chk.sv
module sevgrp_rx_chk #(
  parameter int unsigned MAX_BYTES = 512
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           eop_i,
  input logic                           wr_en_o,
  input logic [$clog2(MAX_BYTES)-1:0]   wr_addr_o,
  input logic                           done_o,
  input logic [$clog2(MAX_BYTES+1)-1:0] done_count_o,
  input logic                           frame_err_o,
  input logic                           ovf_o
);
  localparam int unsigned AW = $clog2(MAX_BYTES);

  logic          seen_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (done_o) begin
      seen_q <= 1'b0;
    end else if (wr_en_o) begin
      seen_q <= 1'b1;
      last_q <= wr_addr_o;
    end
  end

  // R5
  first_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !seen_q) |-> (wr_addr_o == '0));
  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && seen_q) |-> (wr_addr_o == AW'(last_q + AW'(1))));
  // R5
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);
  // R6
  done_after_eop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(eop_i));
  // R7
  no_write_on_ferr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !frame_err_o);
  // R8
  no_write_on_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !ovf_o);
  // R8
  count_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_count_o <= ($clog2(MAX_BYTES+1))'(MAX_BYTES)));
endmodule

bind sevgrp_rx sevgrp_rx_chk #(.MAX_BYTES(MAX_BYTES)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .eop_i        (eop_i),
  .wr_en_o      (wr_en_o),
  .wr_addr_o    (wr_addr_o),
  .done_o       (done_o),
  .done_count_o (done_count_o),
  .frame_err_o  (frame_err_o),
  .ovf_o        (ovf_o)
);

// File: tb/sevgrp_rx_tb_top.sv
`timescale 1ns/1ps
module sevgrp_rx_tb_top;
  localparam int unsigned P   = 8;
  localparam int unsigned MAX = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_i = 1'b0;
  logic       eop_i = 1'b0;
  logic       wr_en_o, done_o, frame_err_o, ovf_o;
  logic [3:0] wr_addr_o;
  logic [7:0] wr_data_o;
  logic [4:0] done_count_o;

  always #4 clk_i = ~clk_i;

  sevgrp_rx #(.CLK_PER_BIT(P), .MAX_BYTES(MAX)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .eop_i(eop_i),
    .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .done_o(done_o), .done_count_o(done_count_o),
    .frame_err_o(frame_err_o), .ovf_o(ovf_o)
  );

  int total = 0;
  int bad   = 0;
  bit ended = 0;
  int nwr   = 0;
  int ndone = 0;
  int done_cnt = 0;
  logic [7:0] exp_data [0:31];
  logic [7:0] got_data [0:63];
  int         got_addr [0:63];

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (wr_en_o) begin
        if (nwr < 64) begin
          got_data[nwr] = wr_data_o;
          got_addr[nwr] = int'(wr_addr_o);
        end
        nwr = nwr + 1;
      end
      if (done_o) begin
        done_cnt = int'(done_count_o);
        ndone = ndone + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_wire(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      rx_i = b[i];
      repeat (P) @(negedge clk_i);
    end
  endtask

  task automatic close_pkt();
    rx_i = 1'b0;
    repeat (2 * P) @(negedge clk_i);
    eop_i = 1'b1;
    @(negedge clk_i);
    eop_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  function automatic logic [7:0] pat_byte(input int pat, input int n, input int i);
    case (pat)
      0:       return 8'h00;
      1:       return 8'hFF;
      2:       return (i % 2 == 0) ? 8'h80 : 8'h7F;
      default: return 8'((i * 37 + n * 11 + 5) & 255);
    endcase
  endfunction

  // R2 R3 R4: bench-side encoding, header bit 6-j carries byte j's top bit
  task automatic send_pkt(input int n);
    logic [7:0] hdr;
    nwr = 0; ndone = 0;
    for (int g = 0; g < n; g += 7) begin
      hdr = 8'h80;
      for (int j = 0; j < 7; j++)
        if (g + j < n) hdr[6-j] = exp_data[g+j][7];
      send_wire(hdr);
      for (int j = 0; j < 7; j++)
        if (g + j < n) send_wire({1'b1, exp_data[g+j][6:0]});
    end
    close_pkt();
  endtask

  task automatic check_pkt(input int stored, input string req);
    chk(ndone == 1, "R6", "done pulse count", ndone, 1);
    chk(done_cnt == stored, "R6", "done_count", done_cnt, stored);
    chk(nwr == stored, req, "write count (R3 header not stored)", nwr, stored);
    for (int i = 0; i < stored && i < nwr; i++) begin
      chk(got_data[i] == exp_data[i], "R4", "restored byte", int'(got_data[i]), int'(exp_data[i]));
      chk(got_addr[i] == i, "R5", "write address", got_addr[i], i);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk_i);
    // R1 reset state
    chk(!wr_en_o, "R1", "wr_en_o", int'(wr_en_o), 0);
    chk(!done_o, "R1", "done_o", int'(done_o), 0);
    chk(!frame_err_o, "R1", "frame_err_o", int'(frame_err_o), 0);
    chk(!ovf_o, "R1", "ovf_o", int'(ovf_o), 0);
    chk(done_count_o == 0, "R1", "done_count_o", int'(done_count_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2 R3 R4 R5 R6: sweep lengths and patterns
    for (int pat = 0; pat < 4; pat++) begin
      for (int n = 0; n <= int'(MAX); n++) begin
        for (int i = 0; i < n; i++) exp_data[i] = pat_byte(pat, n, i);
        send_pkt(n);
        check_pkt(n, "R2");
        chk(!frame_err_o, "R7", "frame_err_o clean packet", int'(frame_err_o), 0);
        chk(!ovf_o, "R8", "ovf_o in-range packet", int'(ovf_o), 0);
      end
    end

    // R8 overflow
    for (int i = 0; i < 21; i++) exp_data[i] = pat_byte(3, 21, i);
    send_pkt(21);
    check_pkt(int'(MAX), "R8");
    chk(ovf_o, "R8", "ovf_o after overflow", int'(ovf_o), 1);

    // R7 framing error after three data bytes
    for (int i = 0; i < 3; i++) exp_data[i] = pat_byte(3, 3, i) ^ 8'hA5;
    nwr = 0; ndone = 0;
    begin
      logic [7:0] hdr;
      hdr = 8'h80;
      for (int j = 0; j < 3; j++) hdr[6-j] = exp_data[j][7];
      send_wire(hdr);
      for (int j = 0; j < 3; j++) send_wire({1'b1, exp_data[j][6:0]});
    end
    send_wire(8'h55);
    send_wire(8'hC3);
    send_wire(8'h81);
    chk(frame_err_o, "R7", "frame_err_o before eop", int'(frame_err_o), 1);
    close_pkt();
    check_pkt(3, "R7");
    chk(frame_err_o, "R7", "frame_err_o held", int'(frame_err_o), 1);

    // R7 R8 flags clear on next packet
    for (int i = 0; i < 9; i++) exp_data[i] = pat_byte(2, 9, i);
    send_pkt(9);
    check_pkt(9, "R7");
    chk(!frame_err_o, "R7", "frame_err_o cleared", int'(frame_err_o), 0);
    chk(!ovf_o, "R8", "ovf_o cleared", int'(ovf_o), 0);

    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule